// File: doc/BRIEF.md
# Segmented Data Memory Address Extender

This block turns the 8-bit data address of a small CPU into a 16-bit physical address and holds the memory behind it. The CPU presents one request per cycle. Each request carries an 8-bit address, an access kind (direct from the instruction, through a pointer, or through the stack pointer), a write flag and write data. The upper half of the 8-bit space is reached without change. The lower half is banked by a segment byte that the CPU writes like any other memory location. Stack accesses always land in bank 0.

The block holds three stores. The first is the bank-0 RAM in the low 112 bytes. The second is one extra 128-byte bank, selected when the segment byte is 1. The third is sixteen register bytes at the top of the space. Four of those bytes hold the segment byte and the X, B and stack pointers, and their values are driven out to the CPU. Any location with nothing behind it reads as 0xFF, ignores writes and raises a flag.

Each request is captured into a stage register at a clock edge. The physical address, read data and flag follow combinationally from that stage during the next cycle. A write commits at the edge that ends that cycle.

Top module: `seg_mem_extender`

## Requirements
- R1: When address bit 7 is 1, the physical address is {0x00, addr}, whatever the segment byte and the access kind.
- R2: When address bit 7 is 0 and the kind is direct (2'b00) or pointer (2'b01), the physical address is {S, 1'b0, addr[6:0]}, where S is the segment byte.
- R3: When address bit 7 is 0 and the kind is stack (2'b10), the physical address uses bank 0, whatever S holds.
- R4: Bank-0 RAM covers physical 0x0000–0x006F. It keeps written bytes and returns them on read.
- R5: Bank 1 (physical 0x0100–0x017F) is a separate 128-byte RAM. A byte in bank 1 does not alias the byte at the same offset in bank 0.
- R6: Register bytes sit at 0xF0–0xFF. The X pointer is at 0xFC, the stack pointer at 0xFD, the B pointer at 0xFE and the segment byte at 0xFF. These four drive their output ports. Writing 0xFF changes the bank used by later lower-half accesses.
- R7: After reset, S is 0x00, the stack pointer is 0x6F, and every other register byte is 0x00.
- R8: Physical 0x0070–0x007F, 0x0080–0x00EF, and the lower half of any bank of 2 or above are unpopulated. For these, `unmapped` is 1 and `rd_data` is 0xFF.
- R9: A write to an unpopulated location changes no stored byte and no register.
- R10: A request is captured at the edge where `req_valid` is 1, and its outputs appear in the following cycle. A write becomes visible one edge later. With `req_valid` low, the stage holds and the outputs stay put.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | Request is a write |
| req_kind | input | 2 | 00 direct, 01 pointer, 10 stack, 11 treated as direct |
| req_addr | input | 8 | CPU data address |
| req_wdata | input | 8 | Write data |
| phys_addr | output | 16 | Physical address of the staged request |
| rd_data | output | 8 | Read data of the staged request |
| unmapped | output | 1 | Staged address has no storage behind it |
| seg_s | output | 8 | Segment byte |
| ptr_x | output | 8 | X pointer byte |
| ptr_sp | output | 8 | Stack pointer byte |
| ptr_b | output | 8 | B pointer byte |

## Verification
The assertions check the following on every cycle: the bank chosen for each half and kind, the 0xFF read of holes, the steadiness of the registers across writes to holes, the hold with no request, and the one-edge visibility of writes. Some behaviour depends on the contents of the stores, and only the scenarios can show it. This covers bank 1 being separate from bank 0, the edges of the RAM ranges, the reset values read back through the bus, and a write to an upper bank leaving the lower banks unchanged.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SEG_BYTES = 128;
  localparam logic [7:0] SP_RESET = 8'h6F;

  typedef enum logic [1:0] {
    KIND_DIRECT = 2'b00,
    KIND_PTR    = 2'b01,
    KIND_STACK  = 2'b10,
    KIND_RSVD   = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'b00,
    TGT_BASE = 2'b01,
    TGT_EXT  = 2'b10,
    TGT_REG  = 2'b11
  } tgt_e;
endpackage

// File: rtl/seg_addr_map.sv
module seg_addr_map
  import seg_pkg::*;
#(
  parameter int BASE_BYTES = 112,
  parameter int EXT_SEGS   = 1,
  parameter int REG_COUNT  = 16,
  parameter int EXT_AW     = 7,
  parameter int REG_AW     = 4
) (
  input  logic [7:0]        addr,
  input  acc_kind_e         kind,
  input  logic [7:0]        seg,
  output logic [15:0]       phys,
  output tgt_e              tgt,
  output logic [6:0]        base_idx,
  output logic [EXT_AW-1:0] ext_idx,
  output logic [REG_AW-1:0] reg_idx
);
  localparam logic [7:0] REG_BASE = 8'(256 - REG_COUNT);
  localparam logic [7:0] BASE_LIM = 8'(BASE_BYTES);
  localparam logic [7:0] EXT_LIM  = 8'(EXT_SEGS);

  logic [7:0] bank;

  always_comb begin
    bank = 8'h00;
    tgt  = TGT_NONE;
    if (addr[7]) begin
      phys = {8'h00, addr};
      if (addr >= REG_BASE) tgt = TGT_REG;
    end else begin
      bank = (kind == KIND_STACK) ? 8'h00 : seg;
      phys = {bank, 1'b0, addr[6:0]};
      if (bank == 8'h00) begin
        if ({1'b0, addr[6:0]} < BASE_LIM) tgt = TGT_BASE;
      end else if (bank <= EXT_LIM) begin
        tgt = TGT_EXT;
      end
    end
  end

  assign base_idx = addr[6:0];
  assign ext_idx  = EXT_AW'({bank - 8'd1, addr[6:0]});
  assign reg_idx  = addr[REG_AW-1:0];
endmodule

// File: rtl/seg_ram_bank.sv
module seg_ram_bank #(
  parameter int DEPTH = 128,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/seg_reg_file.sv
module seg_reg_file
  import seg_pkg::*;
#(
  parameter int REG_COUNT = 16,
  parameter int REG_AW    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] idx,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [7:0]        seg_o,
  output logic [7:0]        sp_o,
  output logic [7:0]        b_o,
  output logic [7:0]        x_o
);
  localparam int S_IDX  = REG_COUNT - 1;
  localparam int B_IDX  = REG_COUNT - 2;
  localparam int SP_IDX = REG_COUNT - 3;
  localparam int X_IDX  = REG_COUNT - 4;

  logic [REG_COUNT-1:0][7:0] regs_q;

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    localparam logic [7:0] RST_VAL = (i == SP_IDX) ? SP_RESET : 8'h00;
    logic       hit;
    logic [7:0] q;
    assign hit = we && (idx == REG_AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= RST_VAL;
      else if (hit) q <= wdata;
    end
    assign regs_q[i] = q;
  end

  assign rdata = regs_q[idx];
  assign seg_o = regs_q[S_IDX];
  assign sp_o  = regs_q[SP_IDX];
  assign b_o   = regs_q[B_IDX];
  assign x_o   = regs_q[X_IDX];

  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && idx == REG_AW'(S_IDX)) |=> $stable(seg_o)); // R6
  AST_RESET_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (seg_o == 8'h00 && sp_o == SP_RESET && x_o == 8'h00)); // R7
endmodule

// File: rtl/seg_mem_extender.sv
module seg_mem_extender
  import seg_pkg::*;
#(
  parameter int BASE_BYTES = 112,
  parameter int EXT_SEGS   = 1,
  parameter int REG_COUNT  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_kind,
  input  logic [7:0]  req_addr,
  input  logic [7:0]  req_wdata,
  output logic [15:0] phys_addr,
  output logic [7:0]  rd_data,
  output logic        unmapped,
  output logic [7:0]  seg_s,
  output logic [7:0]  ptr_x,
  output logic [7:0]  ptr_sp,
  output logic [7:0]  ptr_b
);
  localparam int EXT_DEPTH = ((EXT_SEGS > 0) ? EXT_SEGS : 1) * SEG_BYTES;
  localparam int EXT_AW    = $clog2(EXT_DEPTH);
  localparam int REG_AW    = $clog2(REG_COUNT);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // request stage
  logic [7:0] stg_addr, stg_addr_d;
  acc_kind_e  stg_kind, stg_kind_d;
  logic [7:0] stg_wdata, stg_wdata_d;
  logic       stg_wr, stg_wr_d;

  always_comb begin
    stg_addr_d  = stg_addr;
    stg_kind_d  = stg_kind;
    stg_wdata_d = stg_wdata;
    stg_wr_d    = 1'b0;
    if (req_valid) begin
      stg_addr_d  = req_addr;
      stg_kind_d  = acc_kind_e'(req_kind);
      stg_wdata_d = req_wdata;
      stg_wr_d    = req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      stg_addr  <= 8'h00;
      stg_kind  <= KIND_DIRECT;
      stg_wdata <= 8'h00;
      stg_wr    <= 1'b0;
    end else begin
      stg_addr  <= stg_addr_d;
      stg_kind  <= stg_kind_d;
      stg_wdata <= stg_wdata_d;
      stg_wr    <= stg_wr_d;
    end
  end

  // decode
  tgt_e              tgt;
  logic [6:0]        base_idx;
  logic [EXT_AW-1:0] ext_idx;
  logic [REG_AW-1:0] reg_idx;

  seg_addr_map #(
    .BASE_BYTES(BASE_BYTES),
    .EXT_SEGS  (EXT_SEGS),
    .REG_COUNT (REG_COUNT),
    .EXT_AW    (EXT_AW),
    .REG_AW    (REG_AW)
  ) u_map (
    .addr    (stg_addr),
    .kind    (stg_kind),
    .seg     (seg_s),
    .phys    (phys_addr),
    .tgt     (tgt),
    .base_idx(base_idx),
    .ext_idx (ext_idx),
    .reg_idx (reg_idx)
  );

  // stores
  logic       base_we, ext_we, reg_we;
  logic [7:0] base_rd, ext_rd, reg_rd;

  assign base_we = stg_wr && (tgt == TGT_BASE);
  assign ext_we  = stg_wr && (tgt == TGT_EXT);
  assign reg_we  = stg_wr && (tgt == TGT_REG);

  seg_ram_bank #(.DEPTH(BASE_BYTES), .AW(7)) u_base (
    .clk  (clk),
    .we   (base_we),
    .addr (base_idx),
    .wdata(stg_wdata),
    .rdata(base_rd)
  );

  if (EXT_SEGS > 0) begin : g_ext
    seg_ram_bank #(.DEPTH(EXT_DEPTH), .AW(EXT_AW)) u_ext (
      .clk  (clk),
      .we   (ext_we),
      .addr (ext_idx),
      .wdata(stg_wdata),
      .rdata(ext_rd)
    );
  end else begin : g_no_ext
    assign ext_rd = 8'hFF;
  end

  seg_reg_file #(.REG_COUNT(REG_COUNT), .REG_AW(REG_AW)) u_regs (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .we   (reg_we),
    .idx  (reg_idx),
    .wdata(stg_wdata),
    .rdata(reg_rd),
    .seg_o(seg_s),
    .sp_o (ptr_sp),
    .b_o  (ptr_b),
    .x_o  (ptr_x)
  );

  // read return
  always_comb begin
    unique case (tgt)
      TGT_BASE: rd_data = base_rd;
      TGT_EXT:  rd_data = ext_rd;
      TGT_REG:  rd_data = reg_rd;
      default:  rd_data = 8'hFF;
    endcase
  end
  assign unmapped = (tgt == TGT_NONE);

  AST_UPPER_FLAT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stg_addr[7] |-> phys_addr[15:8] == 8'h00); // R1
  AST_LOWER_BANKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!stg_addr[7] && stg_kind != KIND_STACK) |-> phys_addr[15:8] == seg_s); // R2
  AST_STACK_BANK0: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!stg_addr[7] && stg_kind == KIND_STACK) |-> phys_addr[15:8] == 8'h00); // R3
  AST_HOLE_ONES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    unmapped |-> rd_data == 8'hFF); // R8
  AST_HOLE_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stg_wr && unmapped) |=> ($stable(seg_s) && $stable(ptr_sp) && $stable(ptr_x) && $stable(ptr_b))); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!req_valid && !stg_wr) |=> ($stable(phys_addr) && $stable(rd_data) && $stable(unmapped))); // R10
  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stg_wr && !unmapped && !req_valid) |=> rd_data == $past(stg_wdata)); // R10
endmodule

// File: tb/seg_mem_extender_tb.sv
module seg_mem_extender_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] K_DIR = 2'b00, K_PTR = 2'b01, K_STK = 2'b10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [1:0]  req_kind;
  logic [7:0]  req_addr, req_wdata;
  logic [15:0] phys_addr;
  logic [7:0]  rd_data, seg_s, ptr_x, ptr_sp, ptr_b;
  logic        unmapped;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_mem_extender u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .phys_addr(phys_addr), .rd_data(rd_data), .unmapped(unmapped),
    .seg_s(seg_s), .ptr_x(ptr_x), .ptr_sp(ptr_sp), .ptr_b(ptr_b)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one request; returns at the falling edge after capture
  task automatic access(input logic [1:0] kind, input logic [7:0] addr,
                        input logic we, input logic [7:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_kind = kind; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] kind, input logic [7:0] addr,
                        input logic [15:0] e_phys, input logic e_unm, input logic [7:0] e_rd);
    access(kind, addr, 1'b0, 8'h00);
    chk({tag, " phys"}, phys_addr, e_phys);
    chk({tag, " unmapped"}, {15'd0, unmapped}, {15'd0, e_unm});
    chk({tag, " data"}, {8'd0, rd_data}, {8'd0, e_rd});
  endtask

  task automatic t_reset;
    chk("R7 seg after reset", {8'd0, seg_s}, 16'h0000);
    chk("R7 sp after reset", {8'd0, ptr_sp}, 16'h006F);
    chk("R7 x after reset", {8'd0, ptr_x}, 16'h0000);
    chk("R7 b after reset", {8'd0, ptr_b}, 16'h0000);
    chk("R7 phys after reset", phys_addr, 16'h0000);
    rd_chk("R7 read sp byte", K_DIR, 8'hFD, 16'h00FD, 1'b0, 8'h6F);
  endtask

  task automatic t_base_ram;
    access(K_DIR, 8'h10, 1'b1, 8'hA5);
    access(K_PTR, 8'h6F, 1'b1, 8'h3C);
    access(K_DIR, 8'h00, 1'b1, 8'h81);
    rd_chk("R4 base 0x10", K_DIR, 8'h10, 16'h0010, 1'b0, 8'hA5);
    rd_chk("R4 base top 0x6F", K_PTR, 8'h6F, 16'h006F, 1'b0, 8'h3C);
    rd_chk("R4 base 0x00", K_STK, 8'h00, 16'h0000, 1'b0, 8'h81);
  endtask

  task automatic t_holes;
    rd_chk("R8 hole 0x70", K_DIR, 8'h70, 16'h0070, 1'b1, 8'hFF);
    rd_chk("R8 hole 0x7F", K_DIR, 8'h7F, 16'h007F, 1'b1, 8'hFF);
    rd_chk("R8 upper 0x80", K_DIR, 8'h80, 16'h0080, 1'b1, 8'hFF);
    rd_chk("R8 upper 0xEF", K_DIR, 8'hEF, 16'h00EF, 1'b1, 8'hFF);
    access(K_DIR, 8'h75, 1'b1, 8'h12);
    rd_chk("R9 hole write dropped", K_DIR, 8'h75, 16'h0075, 1'b1, 8'hFF);
    access(K_DIR, 8'h90, 1'b1, 8'h34);
    @(negedge clk);
    chk("R9 upper hole write keeps seg", {8'd0, seg_s}, 16'h0000);
    chk("R9 upper hole write keeps sp", {8'd0, ptr_sp}, 16'h006F);
  endtask

  task automatic t_segments;
    access(K_DIR, 8'hFF, 1'b1, 8'h01);
    @(negedge clk);
    chk("R6 seg port after write", {8'd0, seg_s}, 16'h0001);
    access(K_DIR, 8'h10, 1'b1, 8'h5A);
    access(K_PTR, 8'h7F, 1'b1, 8'h77);
    rd_chk("R5 bank1 0x10", K_DIR, 8'h10, 16'h0110, 1'b0, 8'h5A);
    rd_chk("R5 bank1 top 0x7F", K_PTR, 8'h7F, 16'h017F, 1'b0, 8'h77);
    rd_chk("R3 stack ignores seg", K_STK, 8'h10, 16'h0010, 1'b0, 8'hA5);
    rd_chk("R2 pointer uses seg", K_PTR, 8'h10, 16'h0110, 1'b0, 8'h5A);
    rd_chk("R1 upper ignores seg", K_DIR, 8'hFF, 16'h00FF, 1'b0, 8'h01);
    rd_chk("R1 upper stack kind", K_STK, 8'hFD, 16'h00FD, 1'b0, 8'h6F);
  endtask

  task automatic t_high_banks;
    access(K_DIR, 8'hFF, 1'b1, 8'h02);
    rd_chk("R8 bank2 unpopulated", K_DIR, 8'h10, 16'h0210, 1'b1, 8'hFF);
    access(K_DIR, 8'h10, 1'b1, 8'hEE);
    access(K_DIR, 8'hFF, 1'b1, 8'hFF);
    rd_chk("R2 bank 0xFF phys", K_PTR, 8'h05, 16'hFF05, 1'b1, 8'hFF);
    access(K_DIR, 8'hFF, 1'b1, 8'h01);
    rd_chk("R9 bank1 unchanged", K_DIR, 8'h10, 16'h0110, 1'b0, 8'h5A);
    access(K_DIR, 8'hFF, 1'b1, 8'h00);
    rd_chk("R9 bank0 unchanged", K_DIR, 8'h10, 16'h0010, 1'b0, 8'hA5);
  endtask

  task automatic t_registers;
    access(K_DIR, 8'hFC, 1'b1, 8'h11);
    access(K_DIR, 8'hFE, 1'b1, 8'h22);
    access(K_DIR, 8'hFD, 1'b1, 8'h40);
    access(K_DIR, 8'hF0, 1'b1, 8'h99);
    @(negedge clk);
    chk("R6 x port", {8'd0, ptr_x}, 16'h0011);
    chk("R6 b port", {8'd0, ptr_b}, 16'h0022);
    chk("R6 sp port", {8'd0, ptr_sp}, 16'h0040);
    chk("R6 seg untouched", {8'd0, seg_s}, 16'h0000);
    rd_chk("R6 general reg 0xF0", K_DIR, 8'hF0, 16'h00F0, 1'b0, 8'h99);
  endtask

  task automatic t_timing;
    access(K_DIR, 8'h20, 1'b1, 8'h11);
    access(K_DIR, 8'h20, 1'b1, 8'hC3);
    chk("R10 old data before commit", {8'd0, rd_data}, 16'h0011);
    chk("R10 phys at capture", phys_addr, 16'h0020);
    @(negedge clk);
    chk("R10 new data after commit", {8'd0, rd_data}, 16'h00C3);
    repeat (3) @(negedge clk);
    chk("R10 idle hold phys", phys_addr, 16'h0020);
    chk("R10 idle hold data", {8'd0, rd_data}, 16'h00C3);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_kind = K_DIR; req_addr = 8'h00; req_wdata = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_base_ram();
    t_holes();
    t_segments();
    t_high_banks();
    t_registers();
    t_timing();
    finish_run();
  end
endmodule